// File: doc/BRIEF.md
# Cascadable Latched Sink-Driver Register

The block takes a serial bit stream and presents it as eight parallel drive bits. Each bit controls one low-side sink switch; a 1 turns the switch on. Data moves in on the rising edges of a shift clock. A separate storage clock then copies the whole shift stage into a holding register in one step. The holding register drives the outputs through an active-low enable gate, so a new pattern can be shifted in while the old one stays on the outputs. The analog power stage is not modelled. The drive bits are plain logic levels.

Several blocks can be chained to control more channels. The bit that leaves the top shift position appears on a serial output. That output changes on the falling edge of the shift clock, which gives the next stage half a clock period of hold margin when its shift clock is skewed. A single active-low clear input empties the shift stage, the holding register and the serial output flop at once, with no clock needed.

Top module: `sink_driver_reg`

## Requirements
- R1: On each rising edge of `shclk`, shift-stage bit 0 takes `sdi` and every bit i (i>0) takes the previous bit i-1.
- R2: On each rising edge of `stclk`, all eight shift-stage bits are copied into the holding register. Shifting with no `stclk` edge leaves `drive` unchanged.
- R3: While `clr_n` is 0, the shift stage, the holding register and `sdo` are 0, without any clock edge. The shift stage stays empty after release, so a later `stclk` edge loads zeros.
- R4: While `oe_n` is 1, every bit of `drive` is 0 (all sink switches off), whatever the holding register contains.
- R5: While `oe_n` is 0, `drive[i]` equals holding-register bit i with no clocking, and changes in the same instant as `oe_n`. A 1 means the sink is on.
- R6: `sdo` takes shift-stage bit 7 on the falling edge of `shclk`. A rising edge of `shclk` does not change `sdo`.
- R7: When `shclk` and `stclk` rise together, the holding register captures the shift-stage contents from before that shift.
- R8: Connect two blocks as a chain, with the first block's `sdo` feeding the second block's `sdi`, and let the two shift clocks be skewed by a few ns. After 16 shifts sent most-significant bit first and one `stclk` pulse, the second block's `drive` holds bits 15..8 and the first block's `drive` holds bits 7..0.
- R9: Setting `oe_n` to 1 and then back to 0 restores the same `drive` pattern, because the holding register keeps its value while the outputs are disabled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| shclk | input | 1 | Shift clock; shifts on its rising edge, updates `sdo` on its falling edge |
| stclk | input | 1 | Storage clock; copies the shift stage into the holding register on its rising edge |
| clr_n | input | 1 | Asynchronous active-low clear of all registers |
| oe_n | input | 1 | Active-low output enable for `drive` |
| sdi | input | 1 | Serial data input, enters at shift-stage bit 0 |
| drive | output | 8 | Sink switch controls, 1 = switch on |
| sdo | output | 1 | Cascade serial output, retimed on the falling edge of `shclk` |

## Verification
The bench targets the points where a faulty design would still look plausible.

- A cascade flop clocked on the rising edge would drop or repeat a bit in the chain when the shift clocks are skewed, so the 16-bit patterns would split wrongly between the two output sets.
- A holding register that saw post-shift data when both clocks rise together would show the shifted pattern one step early.
- A clear that reset only the holding register would let stale shift data come back on the next storage pulse.
- An enable that cleared the holding register instead of gating it would lose the pattern across an off/on cycle.

// File: rtl/sdr_pkg.sv
package sdr_pkg;
  parameter int unsigned SDR_WIDTH_DEF = 8;
  localparam logic SINK_ON  = 1'b1;
  localparam logic SINK_OFF = 1'b0;
endpackage

// File: rtl/sdr_shift.sv
module sdr_shift #(
  parameter int unsigned WIDTH = sdr_pkg::SDR_WIDTH_DEF
) (
  input  logic             clk,
  input  logic             clr_n,
  input  logic             sdi,
  output logic [WIDTH-1:0] q
);
  localparam int unsigned TOP = WIDTH - 1;

  logic [WIDTH-1:0] q_nxt;
  logic             armed;

  always_comb begin
    q_nxt = {q[TOP-1:0], sdi};
  end

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) q <= '0;
    else        q <= q_nxt;
  end

  // armed is 1 once a rising edge has passed since the last clear
  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  // R1
  shift_move_chk: assert property (@(posedge clk) disable iff (!clr_n)
    armed |-> (q == {$past(q[TOP-1:0]), $past(sdi)}));
endmodule

// File: rtl/sdr_store.sv
module sdr_store #(
  parameter int unsigned WIDTH = sdr_pkg::SDR_WIDTH_DEF
) (
  input  logic             clk,
  input  logic             clr_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] q_nxt;
  logic             armed;

  always_comb begin
    q_nxt = d;
  end

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) q <= '0;
    else        q <= q_nxt;
  end

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  // R2 R7: the value held now is the shift data sampled at the previous capture edge
  capture_chk: assert property (@(posedge clk) disable iff (!clr_n)
    armed |-> (q == $past(d)));
endmodule

// File: rtl/sdr_cascade.sv
module sdr_cascade (
  input  logic clk,
  input  logic clr_n,
  input  logic d,
  output logic sdo
);
  logic sdo_nxt;

  always_comb begin
    sdo_nxt = d;
  end

  always_ff @(negedge clk or negedge clr_n) begin
    if (!clr_n) sdo <= 1'b0;
    else        sdo <= sdo_nxt;
  end

  // R6: the shift stage only moves on the rising edge, so the copy taken at the
  // falling edge still matches it when the next rising edge arrives
  cascade_track_chk: assert property (@(posedge clk) disable iff (!clr_n)
    sdo == d);
endmodule

// File: rtl/sdr_gate.sv
module sdr_gate #(
  parameter int unsigned WIDTH = sdr_pkg::SDR_WIDTH_DEF
) (
  input  logic             oe_n,
  input  logic [WIDTH-1:0] q,
  output logic [WIDTH-1:0] drive
);
  import sdr_pkg::*;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign drive[i] = (!oe_n && (q[i] == SINK_ON)) ? SINK_ON : SINK_OFF;
  end
endmodule

// File: rtl/sink_driver_reg.sv
module sink_driver_reg #(
  parameter int unsigned WIDTH = sdr_pkg::SDR_WIDTH_DEF
) (
  input  logic             shclk,
  input  logic             stclk,
  input  logic             clr_n,
  input  logic             oe_n,
  input  logic             sdi,
  output logic [WIDTH-1:0] drive,
  output logic             sdo
);
  localparam int unsigned TOP = WIDTH - 1;

  logic [WIDTH-1:0] shift_q;
  logic [WIDTH-1:0] hold_q;

  sdr_shift #(.WIDTH(WIDTH)) u_shift (
    .clk   (shclk),
    .clr_n (clr_n),
    .sdi   (sdi),
    .q     (shift_q)
  );

  sdr_store #(.WIDTH(WIDTH)) u_store (
    .clk   (stclk),
    .clr_n (clr_n),
    .d     (shift_q),
    .q     (hold_q)
  );

  sdr_cascade u_casc (
    .clk   (shclk),
    .clr_n (clr_n),
    .d     (shift_q[TOP]),
    .sdo   (sdo)
  );

  sdr_gate #(.WIDTH(WIDTH)) u_gate (
    .oe_n  (oe_n),
    .q     (hold_q),
    .drive (drive)
  );

  // R4
  off_gate_chk: assert property (@(posedge stclk) disable iff (!clr_n)
    oe_n |-> (drive == '0));

  // R5: an enabled output can never show a sink that the holding register lacks
  on_subset_chk: assert property (@(posedge stclk) disable iff (!clr_n)
    ((drive & ~hold_q) == '0) && ($countones(drive) <= $countones(hold_q)));
endmodule

// File: tb/sim_sink_driver_reg.sv
module sim_sink_driver_reg;
  logic       clk;
  logic       sh0, sh1, st, clr_n, oe_n, sdi;
  logic [7:0] d0, d1;
  logic       so0, so1;
  int         n_chk;
  int         n_bad;
  int         cyc;

  localparam int NV = 6;
  // {oe_n, 16-bit word sent most-significant bit first}
  localparam logic [16:0] VEC [NV] = '{
    {1'b0, 16'hA5C3}, {1'b0, 16'h0001}, {1'b0, 16'h8000},
    {1'b1, 16'hFFFF}, {1'b0, 16'h3C96}, {1'b0, 16'hFFFF}
  };

  sink_driver_reg u0 (.shclk(sh0), .stclk(st), .clr_n(clr_n), .oe_n(oe_n),
                      .sdi(sdi), .drive(d0), .sdo(so0));
  sink_driver_reg u1 (.shclk(sh1), .stclk(st), .clr_n(clr_n), .oe_n(oe_n),
                      .sdi(so0), .drive(d1), .sdo(so1));

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // one shift with u1's clock trailing u0's by 3 ns
  task automatic shift_one(input logic b);
    sdi = b;
    #4 sh0 = 1'b1;
    #3 sh1 = 1'b1;
    #7 sh0 = 1'b0;
    #3 sh1 = 1'b0;
    #3;
  endtask

  task automatic load16(input logic [15:0] w);
    for (int i = 15; i >= 0; i--) shift_one(w[i]);
  endtask

  task automatic store_pulse();
    #2 st = 1'b1;
    #8 st = 1'b0;
    #10;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    n_chk = 0; n_bad = 0; cyc = 0;
    sh0 = 0; sh1 = 0; st = 0; sdi = 0; oe_n = 0; clr_n = 1'b1;
    #1 clr_n = 1'b0;
    #20;
    // R3: reset state
    check("R3 reset drive", {d1, d0}, 16'h0000);
    check("R3 reset sdo", {14'd0, so1, so0}, 16'h0000);
    clr_n = 1'b1;
    #20;

    // vector table: R1 R8 chain loading, R4 gating, R6 cascade bit
    for (int v = 0; v < NV; v++) begin
      oe_n = VEC[v][16];
      load16(VEC[v][15:0]);
      store_pulse();
      check("R1/R8 chain drive", {d1, d0}, VEC[v][16] ? 16'h0000 : VEC[v][15:0]);
      check("R6 tail sdo", {14'd0, so1, so0}, {14'd0, VEC[v][15], VEC[v][7]});
    end

    // R2: shifting without a storage edge leaves drive unchanged
    for (int i = 0; i < 4; i++) shift_one(1'b0);
    check("R2 hold", {d1, d0}, 16'hFFFF);
    store_pulse();
    check("R2 capture", {d1, d0}, 16'hFFF0);

    // R4 R5 R9: enable off then on again
    oe_n = 1'b1;
    #1 check("R4 disabled", {d1, d0}, 16'h0000);
    oe_n = 1'b0;
    #1 check("R5/R9 restored", {d1, d0}, 16'hFFF0);
    #19;

    // R6: sdo moves only on the falling edge
    load16(16'h0040);
    check("R6 before", {15'd0, so0}, 16'h0000);
    sdi = 1'b0;
    #4 begin sh0 = 1'b1; sh1 = 1'b1; end
    #2 check("R6 rising no change", {15'd0, so0}, 16'h0000);
    #8 begin sh0 = 1'b0; sh1 = 1'b0; end
    #1 check("R6 falling update", {15'd0, so0}, 16'h0001);
    #5;

    // R7: both clocks rise together; holding register takes pre-shift data 16'h0080
    sdi = 1'b1;
    #4 begin sh0 = 1'b1; sh1 = 1'b1; st = 1'b1; end
    #5 check("R7 simultaneous", {d1, d0}, 16'h0080);
    #5 begin sh0 = 1'b0; sh1 = 1'b0; st = 1'b0; end
    #6;
    store_pulse();
    check("R7 after shift", {d1, d0}, 16'h0101);

    // R3: asynchronous clear in mid-operation
    load16(16'h8080);
    store_pulse();
    check("R3 preload", {d1, d0, 14'd0, so1, so0} >> 2, {16'h8080, 14'd0, 2'b11} >> 2);
    check("R3 preload sdo", {14'd0, so1, so0}, 16'h0003);
    #3 clr_n = 1'b0;
    #1 check("R3 clear drive", {d1, d0}, 16'h0000);
    check("R3 clear sdo", {14'd0, so1, so0}, 16'h0000);
    #6 clr_n = 1'b1;
    #10;
    store_pulse();
    check("R3 shift stage emptied", {d1, d0}, 16'h0000);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule